// File: doc/BRIEF.md
# Stereo Audio Sample Write Unpacker

The block sits between a register write port and a two-channel serial audio transmitter. Each accepted 32-bit write carries 24-bit audio samples. A 2-bit mode input chooses how the word is read, and the block turns it into a stream of samples. Each sample carries a channel index, 24 data bits, four per-sample control bits and a preamble selection. The biphase coder, the preamble generator, bus decoding and DMA lie outside the block.

There are four modes:

- **Tagged (0):** the top byte names the channel.
- **Alternating (1):** writes go to channel 1 and channel 2 in turn.
- **Packed (2):** three words carry four samples. A byte-regrouping state machine with the states `M2_FIRST`, `M2_SECOND` and `M2_THIRD` steps on each accepted write. The transitions are `M2_FIRST`→`M2_SECOND`→`M2_THIRD`→`M2_FIRST`, and any restart returns it to `M2_FIRST`.
- **Controlled (3):** one sample per word plus a control byte.

The output stage is a second state machine with the states `Q_EMPTY`, `Q_ONE` and `Q_TWO`, which counts the samples waiting. A load moves it from `Q_EMPTY` to `Q_ONE` or to `Q_TWO`. Each output handshake moves it from `Q_TWO` to `Q_ONE`, or from `Q_ONE` to `Q_EMPTY`. The write port accepts a word only when this stage is in `Q_EMPTY`.

Top module: `audio_word_unpacker`

## Requirements
- R1: In mode 0 a write whose bits [31:24] equal 0 yields one sample with data bits [23:0] on channel index 0 (channel 1). A value of 1 yields the sample on channel index 1 (channel 2).
- R2: In mode 0 a write whose bits [31:24] hold any value above 1 produces no sample. `tag_err` is high for exactly the one cycle after that write was accepted and is low otherwise.
- R3: In modes 1 and 3 each write yields one sample from bits [23:0]. The channel index alternates 0,1,0,1… and starts at 0 after reset or after a restart.
- R4: In mode 2 the writes are handled in a cycle of three:
  - The first write yields channel 0 data bits [23:0] and keeps bits [31:24] as the low byte of the next channel 1 sample.
  - The second write yields channel 1 data {bits [15:0], kept byte} and keeps bits [31:16] as the low 16 bits of the next channel 0 sample.
  - The third write yields channel 0 data {bits [7:0], kept 16 bits}, followed by channel 1 data bits [31:8]. The cycle then starts again.
- R5: When one write yields two samples (the third mode 2 write), they leave in the order channel 0 then channel 1.
- R6: In mode 3 the output control bits are taken from the write as follows:
  - `smp_ctrl[0]` is bit 24 (user data).
  - `smp_ctrl[1]` is bit 25 (channel status).
  - `smp_ctrl[2]` is bit 26 (validity).
  - `smp_ctrl[3]` is bit 27 (force parity error).

  Bits [31:30] have no effect on any output.
- R7: In mode 3 with `pre_manual_en` high at the write, `smp_pre_manual` is 1 and `smp_pre_code` equals bits [29:28] (0 block start, 1 channel 1, 2 channel 2). With `pre_manual_en` low, `smp_pre_manual` is 0 and `smp_pre_code` is 0.
- R8: Samples from modes 0, 1 and 2 carry `smp_ctrl`=0, `smp_pre_manual`=0 and `smp_pre_code`=0.
- R9: `wr_ready` is high only while no sample is waiting at the output. A sample that is offered but not taken keeps every output field unchanged until `smp_ready` is high.
- R10: In a cycle where `clear` is high, or where `mode` differs from its value in the previous cycle, `wr_ready` is low. The alternation phase and the mode 2 state return to their start, and any partly assembled mode 2 sample is discarded.
- R11: After reset, `smp_valid` and `tag_err` are 0 and `wr_ready` is 1 when `mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Synchronous restart of the phases |
| mode | input | 2 | Packing format select |
| pre_manual_en | input | 1 | Mode 3: take the preamble type from the word |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word accepted when high with `wr_valid` |
| wr_data | input | 32 | Write word |
| smp_valid | output | 1 | Sample offered |
| smp_ready | input | 1 | Sample taken when high with `smp_valid` |
| smp_chan | output | 1 | Channel index (0 = channel 1, 1 = channel 2) |
| smp_data | output | 24 | Audio sample |
| smp_ctrl | output | 4 | {parity error, validity, status, user} |
| smp_pre_manual | output | 1 | Preamble chosen by `smp_pre_code` |
| smp_pre_code | output | 2 | Preamble type code |
| tag_err | output | 1 | One-cycle pulse for a dropped mode 0 write |

## Verification
The assertions assume that `wr_valid`, `wr_data`, `mode` and `pre_manual_en` are held steady from the cycle a word is offered until it is accepted. They also assume that the mode seen at a write is the mode the queued samples were built under. The stimulus therefore drives these inputs shortly after a rising edge and keeps a write pending until `wr_ready` is seen. It changes `mode` or pulses `clear` only while no write is being offered. Random write data covers both legal and illegal mode 0 tags. `smp_ready` is randomly held low to exercise the hold-while-stalled rule.

// File: rtl/awu_pkg.sv
package awu_pkg;
    parameter int WORD_W  = 32;
    parameter int SMP_W   = 24;
    parameter int CTRL_W  = 4;
    parameter int PCODE_W = 2;
    localparam int TAG_W  = WORD_W - SMP_W;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MD_TAGGED    = 2'd0,
        MD_ALTERNATE = 2'd1,
        MD_PACKED    = 2'd2,
        MD_CONTROL   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        M2_FIRST  = 2'd0,
        M2_SECOND = 2'd1,
        M2_THIRD  = 2'd2
    } m2_state_e;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_ONE   = 2'd1,
        Q_TWO   = 2'd2
    } q_state_e;

    typedef struct packed {
        logic               chan;
        logic [SMP_W-1:0]   data;
        logic [CTRL_W-1:0]  ctrl;
        logic               pman;
        logic [PCODE_W-1:0] pcode;
    } sample_t;
endpackage

// File: rtl/awu_regroup.sv
module awu_regroup
    import awu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [WORD_W-1:0] word,
    output logic [1:0]        n_out,
    output logic [SMP_W-1:0]  first_data,
    output logic              first_chan,
    output logic [SMP_W-1:0]  second_data
);
    localparam int PART_W = 2 * BYTE_W;

    m2_state_e         state_q, state_d;
    logic [PART_W-1:0] part_q, part_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M2_FIRST;
            part_q  <= '0;
        end else begin
            state_q <= state_d;
            part_q  <= part_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        part_d      = part_q;
        n_out       = 2'd0;
        first_data  = '0;
        first_chan  = 1'b0;
        second_data = '0;
        unique case (state_q)
            M2_FIRST: begin
                n_out      = 2'd1;
                first_data = word[SMP_W-1:0];
                first_chan = 1'b0;
                if (step) begin
                    part_d  = {{BYTE_W{1'b0}}, word[WORD_W-1 -: BYTE_W]};
                    state_d = M2_SECOND;
                end
            end
            M2_SECOND: begin
                n_out      = 2'd1;
                first_data = {word[PART_W-1:0], part_q[BYTE_W-1:0]};
                first_chan = 1'b1;
                if (step) begin
                    part_d  = word[WORD_W-1 -: PART_W];
                    state_d = M2_THIRD;
                end
            end
            M2_THIRD: begin
                n_out       = 2'd2;
                first_data  = {word[BYTE_W-1:0], part_q};
                first_chan  = 1'b0;
                second_data = word[WORD_W-1:BYTE_W];
                if (step) begin
                    part_d  = '0;
                    state_d = M2_FIRST;
                end
            end
            default: begin
                state_d = M2_FIRST;
                part_d  = '0;
            end
        endcase
        if (restart) begin
            state_d = M2_FIRST;
            part_d  = '0;
        end
    end
endmodule

// File: rtl/awu_decode.sv
module awu_decode
    import awu_pkg::*;
(
    input  logic              [1:0] mode,
    input  logic              [WORD_W-1:0] word,
    input  logic              alt_phase,
    input  logic              pre_manual_en,
    input  logic              [1:0] m2_n,
    input  logic              [SMP_W-1:0] m2_first,
    input  logic              m2_first_chan,
    input  logic              [SMP_W-1:0] m2_second,
    output logic              [1:0] n_out,
    output sample_t           s0,
    output sample_t           s1,
    output logic              tag_bad
);
    logic [TAG_W-1:0] top_byte;

    always_comb begin
        top_byte = word[WORD_W-1:SMP_W];
        n_out    = 2'd0;
        s0       = '0;
        s1       = '0;
        tag_bad  = 1'b0;
        unique case (mode_e'(mode))
            MD_TAGGED: begin
                s0.data = word[SMP_W-1:0];
                if (top_byte == TAG_W'(0)) begin
                    n_out   = 2'd1;
                    s0.chan = 1'b0;
                end else if (top_byte == TAG_W'(1)) begin
                    n_out   = 2'd1;
                    s0.chan = 1'b1;
                end else begin
                    tag_bad = 1'b1;
                end
            end
            MD_ALTERNATE: begin
                n_out   = 2'd1;
                s0.chan = alt_phase;
                s0.data = word[SMP_W-1:0];
            end
            MD_PACKED: begin
                n_out   = m2_n;
                s0.chan = m2_first_chan;
                s0.data = m2_first;
                s1.chan = 1'b1;
                s1.data = m2_second;
            end
            MD_CONTROL: begin
                n_out   = 2'd1;
                s0.chan = alt_phase;
                s0.data = word[SMP_W-1:0];
                s0.ctrl = word[SMP_W +: CTRL_W];
                s0.pman = pre_manual_en;
                s0.pcode = pre_manual_en ? word[SMP_W+CTRL_W +: PCODE_W] : '0;
            end
            default: n_out = 2'd0;
        endcase
    end
endmodule

// File: rtl/awu_out_queue.sv
module awu_out_queue
    import awu_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  logic    [1:0] load_n,
    input  sample_t in0,
    input  sample_t in1,
    output logic    empty,
    output logic    out_valid,
    input  logic    out_ready,
    output sample_t out_smp
);
    q_state_e state_q, state_d;
    sample_t  slot0_q, slot1_q, slot0_d, slot1_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            state_q <= state_d;
            slot0_q <= slot0_d;
            slot1_q <= slot1_d;
        end
    end

    always_comb begin
        state_d = state_q;
        slot0_d = slot0_q;
        slot1_d = slot1_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (load && load_n != 2'd0) begin
                    slot0_d = in0;
                    slot1_d = in1;
                    state_d = (load_n == 2'd2) ? Q_TWO : Q_ONE;
                end
            end
            Q_ONE: begin
                if (out_ready) state_d = Q_EMPTY;
            end
            Q_TWO: begin
                if (out_ready) begin
                    slot0_d = slot1_q;
                    state_d = Q_ONE;
                end
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    always_comb begin
        empty     = (state_q == Q_EMPTY);
        out_valid = (state_q == Q_ONE) || (state_q == Q_TWO);
        out_smp   = slot0_q;
    end
endmodule

// File: rtl/audio_word_unpacker.sv
module audio_word_unpacker
    import awu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [1:0]        mode,
    input  logic              pre_manual_en,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [WORD_W-1:0] wr_data,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic              smp_chan,
    output logic [SMP_W-1:0]  smp_data,
    output logic [CTRL_W-1:0] smp_ctrl,
    output logic              smp_pre_manual,
    output logic [PCODE_W-1:0] smp_pre_code,
    output logic              tag_err
);
    logic [1:0]       mode_q;
    logic             alt_q;
    logic             tag_err_q;
    logic             restart;
    logic             accept;
    logic             q_empty;
    logic [1:0]       m2_n, dec_n;
    logic [SMP_W-1:0] m2_first, m2_second;
    logic             m2_first_chan;
    logic             dec_tag_bad;
    sample_t          dec_s0, dec_s1, head;

    always_comb begin
        restart  = clear || (mode != mode_q);
        wr_ready = q_empty && !restart;
        accept   = wr_valid && wr_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= 2'd0;
            alt_q     <= 1'b0;
            tag_err_q <= 1'b0;
        end else begin
            mode_q    <= mode;
            tag_err_q <= accept && dec_tag_bad;
            if (restart)
                alt_q <= 1'b0;
            else if (accept && (mode == MD_ALTERNATE || mode == MD_CONTROL))
                alt_q <= ~alt_q;
        end
    end

    awu_regroup u_regroup (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart     (restart),
        .step        (accept && mode == MD_PACKED),
        .word        (wr_data),
        .n_out       (m2_n),
        .first_data  (m2_first),
        .first_chan  (m2_first_chan),
        .second_data (m2_second)
    );

    awu_decode u_decode (
        .mode          (mode),
        .word          (wr_data),
        .alt_phase     (alt_q),
        .pre_manual_en (pre_manual_en),
        .m2_n          (m2_n),
        .m2_first      (m2_first),
        .m2_first_chan (m2_first_chan),
        .m2_second     (m2_second),
        .n_out         (dec_n),
        .s0            (dec_s0),
        .s1            (dec_s1),
        .tag_bad       (dec_tag_bad)
    );

    awu_out_queue u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_n    (dec_n),
        .in0       (dec_s0),
        .in1       (dec_s1),
        .empty     (q_empty),
        .out_valid (smp_valid),
        .out_ready (smp_ready),
        .out_smp   (head)
    );

    always_comb begin
        smp_chan       = head.chan;
        smp_data       = head.data;
        smp_ctrl       = head.ctrl;
        smp_pre_manual = head.pman;
        smp_pre_code   = head.pcode;
        tag_err        = tag_err_q;
    end
endmodule

// File: rtl/awu_checker.sv
module awu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        clear,
    input logic [1:0]  mode,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_data,
    input logic        smp_valid,
    input logic        smp_ready,
    input logic        smp_chan,
    input logic [23:0] smp_data,
    input logic [3:0]  smp_ctrl,
    input logic        smp_pre_manual,
    input logic [1:0]  smp_pre_code,
    input logic        tag_err
);
    AST_READY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> !smp_valid); // R9

    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)
            && $stable(smp_chan) && $stable(smp_ctrl) && $stable(smp_pre_code))); // R9

    AST_ERR_FROM_BAD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        tag_err |-> $past(wr_valid && wr_ready && mode == 2'd0 && wr_data[31:24] > 8'd1)); // R2

    AST_TAG_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(smp_valid) && $past(mode) == 2'd0) |-> (smp_chan == $past(wr_data[24]))); // R1

    AST_NO_CTRL_OUTSIDE_M3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(smp_valid) && $past(mode) != 2'd3) |-> (smp_ctrl == 4'd0 && !smp_pre_manual)); // R8

    AST_CODE_ZERO_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_pre_manual) |-> (smp_pre_code == 2'd0)); // R7

    AST_RESTART_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !wr_ready); // R10
endmodule

bind audio_word_unpacker awu_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (clear),
    .mode           (mode),
    .wr_valid       (wr_valid),
    .wr_ready       (wr_ready),
    .wr_data        (wr_data),
    .smp_valid      (smp_valid),
    .smp_ready      (smp_ready),
    .smp_chan       (smp_chan),
    .smp_data       (smp_data),
    .smp_ctrl       (smp_ctrl),
    .smp_pre_manual (smp_pre_manual),
    .smp_pre_code   (smp_pre_code),
    .tag_err        (tag_err)
);

// File: tb/audio_word_unpacker_test.sv
`timescale 1ns/1ps
module audio_word_unpacker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        pre_manual_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_data = '0;
    logic        smp_valid;
    logic        smp_ready = 1'b1;
    logic        smp_chan;
    logic [23:0] smp_data;
    logic [3:0]  smp_ctrl;
    logic        smp_pre_manual;
    logic [1:0]  smp_pre_code;
    logic        tag_err;

    int checks = 0;
    int errors = 0;
    bit stall_en = 1'b0;

    always #10 clk = ~clk;

    audio_word_unpacker uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .mode(mode),
        .pre_manual_en(pre_manual_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .smp_valid(smp_valid), .smp_ready(smp_ready),
        .smp_chan(smp_chan), .smp_data(smp_data), .smp_ctrl(smp_ctrl),
        .smp_pre_manual(smp_pre_manual), .smp_pre_code(smp_pre_code),
        .tag_err(tag_err)
    );

    // expected sample: {chan, data[23:0], ctrl[3:0], pman, pcode[1:0]}
    logic [31:0] exp_q [0:255];
    string       exp_req [0:255];
    int          head_i = 0, tail_i = 0;
    bit          m_alt;
    int          m_ph;
    logic [15:0] m_part;
    logic [1:0]  m_prev;
    bit          err_exp;
    bit          hold_chk;
    logic [31:0] hold_val;

    function automatic logic [31:0] pack_smp(input logic ch, input logic [23:0] d,
                                             input logic [3:0] c, input logic pm,
                                             input logic [1:0] pc);
        return {ch, d, c, pm, pc};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] s, input string req);
        exp_q[tail_i[7:0]] = s;
        exp_req[tail_i[7:0]] = req;
        tail_i++;
    endtask

    task automatic model_write(input logic [31:0] d);
        logic [1:0] pc;
        case (mode)
            2'd0: begin
                if (d[31:24] == 8'd0)      push(pack_smp(1'b0, d[23:0], 4'd0, 1'b0, 2'd0), "R1/R8");
                else if (d[31:24] == 8'd1) push(pack_smp(1'b1, d[23:0], 4'd0, 1'b0, 2'd0), "R1/R8");
                else err_exp = 1'b1;
            end
            2'd1: begin
                push(pack_smp(m_alt, d[23:0], 4'd0, 1'b0, 2'd0), "R3/R8");
                m_alt = ~m_alt;
            end
            2'd2: begin
                if (m_ph == 0) begin
                    push(pack_smp(1'b0, d[23:0], 4'd0, 1'b0, 2'd0), "R4");
                    m_part = {8'd0, d[31:24]};
                    m_ph = 1;
                end else if (m_ph == 1) begin
                    push(pack_smp(1'b1, {d[15:0], m_part[7:0]}, 4'd0, 1'b0, 2'd0), "R4");
                    m_part = d[31:16];
                    m_ph = 2;
                end else begin
                    push(pack_smp(1'b0, {d[7:0], m_part}, 4'd0, 1'b0, 2'd0), "R4/R5");
                    push(pack_smp(1'b1, d[31:8], 4'd0, 1'b0, 2'd0), "R4/R5");
                    m_ph = 0;
                end
            end
            default: begin
                pc = pre_manual_en ? d[29:28] : 2'd0;
                push(pack_smp(m_alt, d[23:0], d[27:24], pre_manual_en, pc), "R3/R6/R7");
                m_alt = ~m_alt;
            end
        endcase
    endtask

    always @(negedge clk) begin
        logic [31:0] act;
        if (!rst_n) begin
            m_alt = 1'b0; m_ph = 0; m_part = '0; m_prev = 2'd0;
            err_exp = 1'b0; hold_chk = 1'b0;
        end else begin
            check(tag_err == err_exp, "R2", {31'd0, tag_err}, {31'd0, err_exp});
            err_exp = 1'b0;
            check(!(wr_ready && smp_valid), "R9", {31'd0, wr_ready}, 32'd0);
            act = pack_smp(smp_chan, smp_data, smp_ctrl, smp_pre_manual, smp_pre_code);
            if (hold_chk)
                check(smp_valid && act == hold_val, "R9", act, hold_val);
            hold_chk = smp_valid && !smp_ready;
            hold_val = act;
            if (smp_valid && smp_ready) begin
                if (head_i == tail_i) begin
                    check(1'b0, "R2/R9 unexpected sample", act, 32'd0);
                end else begin
                    check(act == exp_q[head_i[7:0]], exp_req[head_i[7:0]], act, exp_q[head_i[7:0]]);
                    head_i++;
                end
            end
            if (clear || mode != m_prev) begin
                check(!wr_ready, "R10", {31'd0, wr_ready}, 32'd0);
                m_alt = 1'b0; m_ph = 0; m_part = '0;
            end else if (wr_valid && wr_ready) begin
                model_write(wr_data);
            end
            m_prev = mode;
        end
    end

    always @(posedge clk) begin
        #2 smp_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
    end

    task automatic do_write(input logic [31:0] d);
        @(posedge clk); #2;
        wr_valid = 1'b1;
        wr_data  = d;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m, input logic pm);
        @(posedge clk); #2;
        mode = m;
        pre_manual_en = pm;
    endtask

    task automatic pulse_clear();
        @(posedge clk); #2; clear = 1'b1;
        @(posedge clk); #2; clear = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((head_i != tail_i || smp_valid) && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(head_i == tail_i, "R9 drain", tail_i - head_i, 32'd0);
    endtask

    function automatic logic [31:0] rand_word(input logic [1:0] m);
        logic [31:0] w = $urandom;
        if (m == 2'd0 && $urandom_range(4) != 0) w[31:24] = {7'd0, w[24]};
        return w;
    endfunction

    task automatic run_all();
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(smp_valid == 1'b0, "R11", {31'd0, smp_valid}, 32'd0);
        check(tag_err == 1'b0, "R11", {31'd0, tag_err}, 32'd0);
        check(wr_ready == 1'b1, "R11", {31'd0, wr_ready}, 32'd1);

        // directed R1, R2
        do_write(32'h00_123456);
        do_write(32'h01_ABCDEF);
        do_write(32'h05_777777);
        do_write(32'hFF_000001);
        drain();
        // directed R4, R5: four samples from three words
        set_mode(2'd2, 1'b0);
        do_write(32'hB0_A2A1A0);
        do_write(32'hC1_C0_B2B1);
        do_write(32'hD2D1D0_C2);
        drain();
        // directed R10: restart after a partial word
        do_write(32'h11_223344);
        pulse_clear();
        do_write(32'h55_667788);
        drain();
        // directed R6, R7: top bits ignored, manual preamble
        set_mode(2'd3, 1'b1);
        do_write(32'hDF_010203);
        do_write(32'h20_040506);
        set_mode(2'd3, 1'b0);
        do_write(32'hFF_070809);
        drain();

        // random segments
        stall_en = 1'b1;
        for (int seg = 0; seg < 60; seg++) begin
            logic [1:0] m = 2'($urandom_range(3));
            set_mode(m, 1'($urandom_range(1)));
            for (int k = 0; k < 1 + int'($urandom_range(12)); k++) begin
                do_write(rand_word(m));
                if ($urandom_range(15) == 0) pulse_clear();
            end
            if ($urandom_range(1) == 0) drain();
        end
        stall_en = 1'b0;
        drain();
        repeat (4) @(posedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule